// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is the counting engine of a general-purpose timer. One register counts the ticks it is given. Four modes decide what a wrap, a compare hit or an outside strobe does to that count. In free-running mode the count wraps and reports overflows. Pulse-width mode adds a capture strobe that latches the count and restarts it. Encoder mode clears on compare hits and on home-position signals, and can be preloaded when it starts. Triangle mode counts up to a buffered period, back down to zero, and up again.

Starting the counter (a rising edge of the enable) puts the count at all-ones. The first step from all-ones to zero is the start of the count, not an overflow. Overflows are kept in two sticky flags, one for the timer modes and one for encoder mode. Both flags share one overflow pulse. A single match pulse marks compare hits and triangle peaks. Tick qualification, quadrature decoding and waveform output belong to neighbouring blocks.

Top module: `mmt_core`

## Requirements
- R1: After reset, `count`, `cap_val`, both flags and both pulses are zero.
- R2: On a rising edge of `cnt_en`, `count` becomes all-ones (unless R9 applies) and no tick is counted in that cycle. Modes: 0 free-running, 1 pulse-width, 2 encoder, 3 triangle.
- R3: The first step from the start value all-ones to zero raises neither `ovf_irq`, `match_irq` nor any flag.
- R4: In modes 0 and 1, a later tick at all-ones wraps the count to zero, sets `tmr_ovf` and pulses `ovf_irq` for one cycle.
- R5: In mode 2, a wrap from all-ones sets `enc_ovf`, leaves `tmr_ovf` unchanged and pulses `ovf_irq`.
- R6: In mode 2, a tick with `count == cmp_val` clears the count to zero and pulses `match_irq`. When `cmp_val` is all-ones, this clear raises no overflow.
- R7: In mode 1, `cap_stb` copies `count` into `cap_val` and clears the count, taking priority over a tick in the same cycle. Capturing all-ones raises no overflow. In other modes `cap_stb` has no effect.
- R8: In mode 2, `home_edge` or `home_lvl` clears the count to zero whether or not a tick arrives.
- R9: In mode 2 with `ld_defer` low, a start loads `load_val` instead of all-ones.
- R10: In mode 3 the count rises to the buffered period, pulses `match_irq` and steps down. It then falls to zero, steps up to one and reloads the buffer from `period_val`. This mode never overflows.
- R11: Both flags stay set until `ovf_clr`. A set in the same cycle wins over the clear.
- R12: While `cnt_en` is low the count holds and no pulse is raised.
- R13: In mode 0, a tick with `count == cmp_val` pulses `match_irq` without clearing the count. A count that is still the start value does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable; its rising edge starts the counter |
| tick | input | 1 | Count step qualifier |
| mode | input | 2 | Mode select (0 free, 1 pulse-width, 2 encoder, 3 triangle) |
| cmp_val | input | WIDTH | Compare value |
| period_val | input | WIDTH | Triangle period, buffered at start and at each valley |
| cap_stb | input | 1 | Capture strobe (pulse-width mode) |
| home_edge | input | 1 | Detected home edge (encoder mode) |
| home_lvl | input | 1 | Home level condition met (encoder mode) |
| ld_defer | input | 1 | Low: encoder start loads `load_val` |
| load_val | input | WIDTH | Encoder start value |
| ovf_clr | input | 1 | Clear strobe for both overflow flags |
| count | output | WIDTH | Counter value |
| cap_val | output | WIDTH | Last captured value |
| tmr_ovf | output | 1 | Sticky overflow flag, modes 0 and 1 |
| enc_ovf | output | 1 | Sticky overflow flag, mode 2 |
| ovf_irq | output | 1 | One-cycle overflow pulse |
| match_irq | output | 1 | One-cycle compare-match / peak pulse |

## Verification
The bench builds the core with WIDTH = 8. A full lap of the counter is then 256 ticks, so overflows, compare hits at the all-ones value and captures of all-ones come up many times in a few thousand random cycles. At the default width they would need about 65,000 ticks each. Short triangle periods and random home and capture strobes let every clear source collide with a wrap.

// File: rtl/mmt_pkg.sv
// Shared types for the multi-mode timer core.
package mmt_pkg;
    typedef enum logic [1:0] {
        MD_FREE  = 2'd0,
        MD_PULSE = 2'd1,
        MD_ENC   = 2'd2,
        MD_TRI   = 2'd3
    } mode_e;
endpackage

// File: rtl/mmt_event_decode.sv
// Event decoder: turns the current count state and strobes into one-hot-ish
// action requests for the counter register and the flag unit.
// Assumes: mode is stable while running; clears beat tick actions.
module mmt_event_decode
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            md,
    input  logic             running,
    input  logic             tick,
    input  logic             cap_stb,
    input  logic             home_edge,
    input  logic             home_lvl,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic [WIDTH-1:0] period_buf,
    input  logic             dir_down,
    input  logic             first,
    output logic             evt_cap,
    output logic             evt_home,
    output logic             evt_cmp_clr,
    output logic             evt_wrap,
    output logic             evt_ovf,
    output logic             evt_match,
    output logic             evt_peak,
    output logic             evt_valley,
    output logic             evt_inc,
    output logic             evt_dec
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    logic tk, at_ones, cmp_hit, tri_dn;

    // Decode the action for this cycle, clears first.
    always_comb begin
        evt_cap     = running && (md == MD_PULSE) && cap_stb;
        evt_home    = running && (md == MD_ENC) && (home_edge || home_lvl);
        tk          = running && tick && !evt_cap && !evt_home;
        at_ones     = (count == ONES);
        cmp_hit     = (count == cmp_val) && !first;
        tri_dn      = (md == MD_TRI) && dir_down;
        evt_cmp_clr = tk && (md == MD_ENC) && cmp_hit;
        evt_peak    = tk && (md == MD_TRI) && !dir_down && (count == period_buf) && !first;
        evt_valley  = tk && tri_dn && (count == '0);
        evt_wrap    = tk && at_ones && !evt_cmp_clr && !evt_peak && !tri_dn;
        evt_ovf     = evt_wrap && !first && (md != MD_TRI);
        evt_match   = (tk && (md == MD_FREE) && cmp_hit) || evt_cmp_clr || evt_peak;
        evt_dec     = tk && tri_dn && !evt_valley;
        evt_inc     = tk && !evt_cmp_clr && !evt_peak && !evt_wrap && !tri_dn;
    end

    // R3
    first_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first && running && tick) |-> (!evt_ovf && !evt_match));

endmodule

// File: rtl/mmt_count_reg.sv
// Counter state: count, direction, start marker, period buffer, capture.
// Assumes: start (rising cnt_en) outranks every other action that cycle.
module mmt_count_reg
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            md,
    input  logic             cnt_en,
    input  logic             ld_defer,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] period_val,
    input  logic             evt_cap,
    input  logic             evt_home,
    input  logic             evt_cmp_clr,
    input  logic             evt_wrap,
    input  logic             evt_peak,
    input  logic             evt_valley,
    input  logic             evt_inc,
    input  logic             evt_dec,
    output logic             running,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] cap_val,
    output logic [WIDTH-1:0] period_buf,
    output logic             dir_down,
    output logic             first
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    logic             en_q;
    logic             start;
    logic [WIDTH-1:0] start_val;

    assign start     = cnt_en && !en_q;
    assign running   = cnt_en && en_q;
    assign start_val = ((md == MD_ENC) && !ld_defer) ? load_val : ONES;

    // Remember the enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= cnt_en;
    end

    // Update count, direction, period buffer and capture value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            cap_val    <= '0;
            period_buf <= '0;
            dir_down   <= 1'b0;
            first      <= 1'b0;
        end else if (start) begin
            count      <= start_val;
            first      <= (start_val == ONES);
            dir_down   <= 1'b0;
            period_buf <= period_val;
        end else begin
            if (evt_cap) begin
                cap_val <= count;
                count   <= '0;
            end else if (evt_home || evt_cmp_clr || evt_wrap) begin
                count <= '0;
            end else if (evt_peak) begin
                dir_down <= 1'b1;
                count    <= count - 1'b1;
            end else if (evt_valley) begin
                dir_down   <= 1'b0;
                count      <= {{(WIDTH-1){1'b0}}, 1'b1};
                period_buf <= period_val;
            end else if (evt_inc) begin
                count <= count + 1'b1;
            end else if (evt_dec) begin
                count <= count - 1'b1;
            end
            if (evt_cap || evt_home || evt_cmp_clr || evt_wrap || evt_peak ||
                evt_valley || evt_inc || evt_dec)
                first <= 1'b0;
        end
    end

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !en_q && !((md == MD_ENC) && !ld_defer)) |=> (count == ONES));

    // R6
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cmp_clr && en_q && cnt_en) |=> (count == '0));

endmodule

// File: rtl/mmt_flag_unit.sv
// Overflow flags and event pulses, all registered.
// Assumes: a set outranks a software clear in the same cycle.
module mmt_flag_unit
    import mmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e md,
    input  logic  evt_ovf,
    input  logic  evt_match,
    input  logic  ovf_clr,
    output logic  tmr_ovf,
    output logic  enc_ovf,
    output logic  ovf_irq,
    output logic  match_irq
);
    logic set_tmr, set_enc;

    assign set_tmr = evt_ovf && (md != MD_ENC);
    assign set_enc = evt_ovf && (md == MD_ENC);

    // Register the pulses and keep the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_ovf   <= 1'b0;
            enc_ovf   <= 1'b0;
            ovf_irq   <= 1'b0;
            match_irq <= 1'b0;
        end else begin
            ovf_irq   <= evt_ovf;
            match_irq <= evt_match;
            if (set_tmr)      tmr_ovf <= 1'b1;
            else if (ovf_clr) tmr_ovf <= 1'b0;
            if (set_enc)      enc_ovf <= 1'b1;
            else if (ovf_clr) enc_ovf <= 1'b0;
        end
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !ovf_clr) |=> tmr_ovf);

    // R4
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (tmr_ovf || enc_ovf));

    // R10
    tri_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_TRI) |-> !evt_ovf);

endmodule

// File: rtl/mmt_core.sv
// Multi-mode timer counter core: ties the event decoder, counter register
// and flag unit together. Assumes inputs are synchronous to clk.
module mmt_core
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic [WIDTH-1:0] period_val,
    input  logic             cap_stb,
    input  logic             home_edge,
    input  logic             home_lvl,
    input  logic             ld_defer,
    input  logic [WIDTH-1:0] load_val,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] cap_val,
    output logic             tmr_ovf,
    output logic             enc_ovf,
    output logic             ovf_irq,
    output logic             match_irq
);
    mode_e            md;
    logic             running, dir_down, first;
    logic [WIDTH-1:0] period_buf;
    logic evt_cap, evt_home, evt_cmp_clr, evt_wrap, evt_ovf, evt_match;
    logic evt_peak, evt_valley, evt_inc, evt_dec;

    assign md = mode_e'(mode);

    mmt_event_decode #(.WIDTH(WIDTH)) u_dec (
        .clk(clk), .rst_n(rst_n), .md(md), .running(running), .tick(tick),
        .cap_stb(cap_stb), .home_edge(home_edge), .home_lvl(home_lvl),
        .count(count), .cmp_val(cmp_val), .period_buf(period_buf),
        .dir_down(dir_down), .first(first),
        .evt_cap(evt_cap), .evt_home(evt_home), .evt_cmp_clr(evt_cmp_clr),
        .evt_wrap(evt_wrap), .evt_ovf(evt_ovf), .evt_match(evt_match),
        .evt_peak(evt_peak), .evt_valley(evt_valley),
        .evt_inc(evt_inc), .evt_dec(evt_dec)
    );

    mmt_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .md(md), .cnt_en(cnt_en),
        .ld_defer(ld_defer), .load_val(load_val), .period_val(period_val),
        .evt_cap(evt_cap), .evt_home(evt_home), .evt_cmp_clr(evt_cmp_clr),
        .evt_wrap(evt_wrap), .evt_peak(evt_peak), .evt_valley(evt_valley),
        .evt_inc(evt_inc), .evt_dec(evt_dec),
        .running(running), .count(count), .cap_val(cap_val),
        .period_buf(period_buf), .dir_down(dir_down), .first(first)
    );

    mmt_flag_unit u_flg (
        .clk(clk), .rst_n(rst_n), .md(md), .evt_ovf(evt_ovf),
        .evt_match(evt_match), .ovf_clr(ovf_clr),
        .tmr_ovf(tmr_ovf), .enc_ovf(enc_ovf),
        .ovf_irq(ovf_irq), .match_irq(match_irq)
    );

    // R7
    cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cap |=> (count == '0 && !ovf_irq));

endmodule

// File: tb/tb_mmt_core.sv
`timescale 1ns/1ps
module tb_mmt_core;
    localparam int W = 8;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 0, tick = 0, cap_stb = 0, home_edge = 0, home_lvl = 0;
    logic ld_defer = 1, ovf_clr = 0;
    logic [1:0] mode = 0;
    logic [W-1:0] cmp_val = 0, period_val = 1, load_val = 0;
    logic [W-1:0] count, cap_val;
    logic tmr_ovf, enc_ovf, ovf_irq, match_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mmt_core #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick), .mode(mode),
        .cmp_val(cmp_val), .period_val(period_val), .cap_stb(cap_stb),
        .home_edge(home_edge), .home_lvl(home_lvl), .ld_defer(ld_defer),
        .load_val(load_val), .ovf_clr(ovf_clr), .count(count),
        .cap_val(cap_val), .tmr_ovf(tmr_ovf), .enc_ovf(enc_ovf),
        .ovf_irq(ovf_irq), .match_irq(match_irq)
    );

    // Reference model, stepped on each rising edge from the requirements.
    logic [W-1:0] m_cnt, m_cap, m_pbuf;
    logic m_en, m_first, m_down, m_tfl, m_efl, m_ovf, m_match;

    function automatic logic [W-1:0] inc1(input logic [W-1:0] v);
        return v + 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_pbuf = 0; m_en = 0; m_first = 0;
            m_down = 0; m_tfl = 0; m_efl = 0; m_ovf = 0; m_match = 0;
        end else begin
            logic ovf, mt;
            ovf = 0; mt = 0;
            if (cnt_en && !m_en) begin
                m_cnt   = (mode == 2 && !ld_defer) ? load_val : ONES;
                m_first = (m_cnt == ONES);
                m_down  = 0;
                m_pbuf  = period_val;
            end else if (cnt_en) begin
                if (mode == 1 && cap_stb) begin
                    m_cap = m_cnt; m_cnt = 0; m_first = 0;
                end else if (mode == 2 && (home_edge || home_lvl)) begin
                    m_cnt = 0; m_first = 0;
                end else if (tick) begin
                    if (mode == 3) begin
                        if (!m_down) begin
                            if (m_cnt == m_pbuf && !m_first) begin
                                m_down = 1; m_cnt = m_cnt - 1'b1; mt = 1;
                            end else if (m_cnt == ONES) m_cnt = 0;
                            else m_cnt = inc1(m_cnt);
                        end else if (m_cnt == 0) begin
                            m_down = 0; m_cnt = 1; m_pbuf = period_val;
                        end else m_cnt = m_cnt - 1'b1;
                    end else if (mode == 2 && m_cnt == cmp_val && !m_first) begin
                        m_cnt = 0; mt = 1;
                    end else begin
                        if (mode == 0 && m_cnt == cmp_val && !m_first) mt = 1;
                        if (m_cnt == ONES) begin
                            ovf = !m_first; m_cnt = 0;
                        end else m_cnt = inc1(m_cnt);
                    end
                    m_first = 0;
                end
            end
            if (ovf && mode != 2) m_tfl = 1; else if (ovf_clr) m_tfl = 0;
            if (ovf && mode == 2) m_efl = 1; else if (ovf_clr) m_efl = 0;
            m_ovf = ovf; m_match = mt;
            m_en = cnt_en;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tk();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] tri_exp [13];
        void'($urandom(32'd2024));
        repeat (3) tk();
        // R1 reset state
        chk("R1 count", count, 0); chk("R1 cap", cap_val, 0);
        chk("R1 flags", {tmr_ovf, enc_ovf}, 0); chk("R1 pulses", {ovf_irq, match_irq}, 0);
        rst_n = 1; tk();

        // Free-running: start, first wrap, compare, overflow
        mode = 0; cmp_val = 0; cnt_en = 1; tick = 0; tk();
        chk("R2 start value", count, ONES);
        tick = 1; tk();
        chk("R3 first wrap count", count, 0);
        chk("R3 no pulse on first wrap", {ovf_irq, match_irq, tmr_ovf}, 0);
        tk();
        chk("R13 match pulse", match_irq, 1); chk("R13 no clear", count, 1);
        cap_stb = 1; tk(); cap_stb = 0;
        chk("R7 capture ignored in mode 0", {count, cap_val}, {8'd2, 8'd0});
        repeat (253) tk();
        chk("R4 at all-ones", count, ONES);
        tk();
        chk("R4 wrap", count, 0); chk("R4 ovf pulse", ovf_irq, 1);
        chk("R4 timer flag", {tmr_ovf, enc_ovf}, 2'b10);
        tk();
        chk("R4 pulse one cycle", ovf_irq, 0); chk("R11 flag sticky", tmr_ovf, 1);
        tick = 0; ovf_clr = 1; tk(); ovf_clr = 0;
        chk("R11 flag cleared", tmr_ovf, 0);
        cnt_en = 0; tick = 1; held = count; tk();
        chk("R12 hold", count, held); tk();
        chk("R12 hold again", count, held); chk("R12 no pulse", {ovf_irq, match_irq}, 0);

        // Pulse-width: capture of all-ones
        mode = 1; cnt_en = 1; tick = 0; tk(); tick = 1; tk();
        repeat (255) tk();
        chk("R7 reached all-ones", count, ONES);
        cap_stb = 1; tk(); cap_stb = 0;
        chk("R7 captured", cap_val, ONES); chk("R7 cleared", count, 0);
        chk("R7 no ovf", {ovf_irq, tmr_ovf}, 0);

        // Encoder: load on start, compare at all-ones, overflow, home clears
        cnt_en = 0; tick = 0; tk();
        mode = 2; ld_defer = 0; load_val = 8'hFD; cmp_val = ONES; cnt_en = 1; tk();
        chk("R9 loaded", count, 8'hFD);
        tick = 1; tk(); tk();
        chk("R6 at all-ones", count, ONES);
        tk();
        chk("R6 cleared", count, 0); chk("R6 match", match_irq, 1);
        chk("R6 no ovf", {ovf_irq, enc_ovf}, 0);
        cnt_en = 0; tk();
        load_val = 8'hF0; cmp_val = 8'h05; cnt_en = 1; tick = 0; tk();
        tick = 1; repeat (15) tk();
        chk("R5 at all-ones", count, ONES);
        ovf_clr = 1; tk(); ovf_clr = 0;
        chk("R5 wrap", count, 0); chk("R5 ovf pulse", ovf_irq, 1);
        chk("R11 set wins", {tmr_ovf, enc_ovf}, 2'b01);
        repeat (3) tk();
        home_edge = 1; tk(); home_edge = 0;
        chk("R8 edge clear", count, 0);
        tk(); tick = 0; home_lvl = 1; tk(); home_lvl = 0;
        chk("R8 level clear", count, 0);

        // Triangle: peak, valley, period reload
        cnt_en = 0; tk();
        mode = 3; period_val = 3; cnt_en = 1; tk();
        chk("R10 start", count, ONES);
        period_val = 5; tick = 1;
        tri_exp = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd2, 8'd1, 8'd0, 8'd1,
                    8'd2, 8'd3, 8'd4, 8'd5, 8'd4};
        for (int i = 0; i < 13; i++) begin
            tk();
            chk("R10 sequence", count, tri_exp[i]);
            chk("R10 peak pulse", match_irq, (i == 4 || i == 12) ? 1 : 0);
            chk("R10 no overflow", ovf_irq, 0);
        end

        // Random phase against the model
        tick = 0; cnt_en = 0; tk();
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(99) < 3) begin
                cnt_en = 0;
                mode = 2'($urandom_range(3));
                ld_defer = 1'($urandom_range(1));
                load_val = W'($urandom_range(255));
                period_val = W'($urandom_range(40, 1));
                cmp_val = ($urandom_range(3) == 0) ? ONES : W'($urandom_range(255));
            end else cnt_en = 1;
            tick = ($urandom_range(99) < 80);
            cap_stb = ($urandom_range(99) < 3);
            home_edge = ($urandom_range(99) < 2);
            home_lvl = ($urandom_range(199) < 1);
            ovf_clr = ($urandom_range(99) < 3);
            tk();
            chk("R2 count vs model", count, m_cnt);
            chk("R7 capture vs model", cap_val, m_cap);
            chk("R4 timer flag vs model", tmr_ovf, m_tfl);
            chk("R5 encoder flag vs model", enc_ovf, m_efl);
            chk("R3 ovf pulse vs model", ovf_irq, m_ovf);
            chk("R6 match pulse vs model", match_irq, m_match);
        end
        finish_run();
    end
endmodule